// File: doc/BRIEF.md
# Password-Gated Secure Zone Controller

This block sits on the data-read path of an embedded processor and guards a secure memory zone made of a flash range, a secure RAM range and the flash configuration registers. Every read carries two addresses: the address being read and the address of the instruction that issued it. While the zone is locked, a read of a secure address by code outside the secure code regions is masked to zero and flagged. Reads issued by code inside the secure regions always pass. Fetches are not filtered, so non-secure code can branch into secure code and run there.

Software writes a 128-bit key as eight 16-bit words over a simple register write port. The stored password is the eight 16-bit words at the top of the protected flash, word addresses `0x3F7FF8` through `0x3F7FFF`. The controller takes these words from the raw memory data as they are read. Nothing unlocks until every one of the eight password words has been read since the last key write or reset. Unlocking has two levels. A full 128-bit match opens the zone. A match on the lower 64 bits releases only the debug lock, and secure data stays hidden.

Top module: `seczone_ctrl`

## Requirements
- R1: After reset, `zone_locked` and `dbg_locked` are both 1 and `rd_viol` is 0, whatever state came before the reset.
- R2: Neither lock is released until each of the eight password word addresses `0x3F7FF8`..`0x3F7FFF` has been read at least once since the last key write or reset. The reads may come in any order, and reading a word again does not stand in for a missing one.
- R3: Key word i (written with `key_wr_idx` = i) is compared with the word at `0x3F7FF8`+i, and word 0 is the least significant. When all eight words match and the read pass is complete, both locks read 0 in the cycle after the final pass read.
- R4: When only key words 0..3 match their password words and the pass is complete, `dbg_locked` is 0 while `zone_locked` stays 1, and secure data reads from non-secure code stay blocked.
- R5: When password words 0..3 are all `0xFFFF`, a completed pass releases `dbg_locked` even if no key word matches.
- R6: When all eight password words are `0xFFFF`, a completed pass releases `zone_locked` whatever the key holds.
- R7: A key write discards read-pass progress. Both locks read 1 in the cycle after the write, even if the key value is unchanged, until a new full pass is made.
- R8: While the zone is locked, a read of a secure address (flash `0x3E8000`..`0x3F7FFF`, secure RAM `0x008000`..`0x009FFF`) issued by code outside those ranges returns 0 on `rd_data_out` in the same cycle. `rd_viol` is then 1 for exactly the following cycle.
- R9: Reads issued by code located in the secure flash or secure RAM range return the memory data unmasked and raise no violation.
- R10: Addresses outside the secure zone, including ordinary peripheral registers, pass unmasked to any code. The flash configuration range `0x000A80`..`0x000ADF` is treated as secure data and is blocked for non-secure code while locked.
- R11: While the zone is locked, a read of a password word from non-secure code is masked to 0 but raises no violation.
- R12: While the zone is unlocked, every read returns the memory data unmasked and `rd_viol` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| key_wr_en | input | 1 | Key word write strobe |
| key_wr_idx | input | 3 | Key word index (0 = least significant) |
| key_wr_data | input | 16 | Key word value |
| rd_req | input | 1 | Data read in this cycle |
| rd_addr | input | 22 | Word address being read |
| rd_code_addr | input | 22 | Address of the instruction issuing the read |
| rd_mem_data | input | 16 | Raw data from memory for this read |
| rd_data_out | output | 16 | Data returned to the processor, masked when blocked |
| zone_locked | output | 1 | Secure zone lock flag |
| dbg_locked | output | 1 | Debug stepping lock flag |
| rd_viol | output | 1 | One-cycle pulse after a blocked read |

## Verification
The bench builds the controller with its default parameters. These are a 22-bit word address, eight 16-bit key words, the password block at `0x3F7FF8`, and flash, secure RAM and flash-configuration windows at their default bases. With these values the real window edges, such as the word just below flash and just above secure RAM, can be driven directly, and the password block sits at the very top of the flash window. The 8-word key makes the lower half exactly four words, so a half match, an all-ones lower half and a full all-ones password can each be set up through the bench's memory model. Pass progress is tested with an out-of-order pass, a repeated word, and a key rewrite with an unchanged value.

// File: rtl/sz_pkg.sv
`timescale 1ns/1ps
package sz_pkg;

  // Inclusive window test on zero-extended word addresses.
  function automatic logic in_win(input logic [31:0] a,
                                  input logic [31:0] lo,
                                  input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Upper bound of a window that starts at base and spans n words.
  function automatic logic [31:0] win_top(input logic [31:0] base,
                                          input int unsigned n);
    return base + 32'(n) - 32'd1;
  endfunction

endpackage

// File: rtl/sz_key_bank.sv
`timescale 1ns/1ps
module sz_key_bank #(
  parameter int WORD_W    = 16,
  parameter int KEY_WORDS = 8,
  localparam int IDX_W    = $clog2(KEY_WORDS),
  localparam int KEY_W    = KEY_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [KEY_W-1:0]  key_flat
);

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_kw
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        word_q <= wr_data;
    end
    assign key_flat[g*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/sz_pw_tracker.sv
`timescale 1ns/1ps
module sz_pw_tracker
  import sz_pkg::*;
#(
  parameter int          ADDR_W    = 22,
  parameter int          WORD_W    = 16,
  parameter int          KEY_WORDS = 8,
  parameter logic [31:0] PW_BASE   = 32'h003F_7FF8,
  localparam int IDX_W = $clog2(KEY_WORDS),
  localparam int KEY_W = KEY_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_mem_data,
  output logic              pw_hit,
  output logic              pass_done,
  output logic [KEY_W-1:0]  pw_flat
);

  logic [IDX_W-1:0]     pw_idx;
  logic [KEY_WORDS-1:0] seen;

  assign pw_hit = in_win(32'(rd_addr), PW_BASE, win_top(PW_BASE, KEY_WORDS));
  assign pw_idx = IDX_W'(32'(rd_addr) - PW_BASE);

  // One flag and one shadow word per password location.
  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_pw
    logic [WORD_W-1:0] shadow_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen[g]  <= 1'b0;
        shadow_q <= '0;
      end else if (key_wr) begin
        seen[g]  <= 1'b0;
      end else if (rd_req && pw_hit && (pw_idx == IDX_W'(g))) begin
        seen[g]  <= 1'b1;
        shadow_q <= rd_mem_data;
      end
    end
    assign pw_flat[g*WORD_W +: WORD_W] = shadow_q;
  end

  assign pass_done = &seen;

  // R7: a key write always discards pass progress.
  a_r7_key_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> !pass_done);

  // R2: pass completes only after a read of a password word.
  a_r2_done_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_done) |-> $past(rd_req && pw_hit));

endmodule

// File: rtl/sz_lock_eval.sv
`timescale 1ns/1ps
module sz_lock_eval #(
  parameter int WORD_W    = 16,
  parameter int KEY_WORDS = 8,
  localparam int KEY_W    = KEY_WORDS * WORD_W,
  localparam int HALF_W   = KEY_W / 2
) (
  input  logic [KEY_W-1:0] key_flat,
  input  logic [KEY_W-1:0] pw_flat,
  input  logic             pass_done,
  output logic             zone_locked,
  output logic             dbg_locked
);

  logic full_match, low_match, pw_blank, low_blank;

  always_comb begin
    full_match  = (key_flat == pw_flat);
    low_match   = (key_flat[HALF_W-1:0] == pw_flat[HALF_W-1:0]);
    pw_blank    = &pw_flat;
    low_blank   = &pw_flat[HALF_W-1:0];
    zone_locked = !(pass_done && (full_match || pw_blank));
    dbg_locked  = !(pass_done && (low_match || low_blank));
  end

endmodule

// File: rtl/sz_access_filter.sv
`timescale 1ns/1ps
module sz_access_filter
  import sz_pkg::*;
#(
  parameter int          ADDR_W   = 22,
  parameter int          WORD_W   = 16,
  parameter logic [31:0] FLASH_LO = 32'h003E_8000,
  parameter logic [31:0] FLASH_HI = 32'h003F_7FFF,
  parameter logic [31:0] SRAM_LO  = 32'h0000_8000,
  parameter logic [31:0] SRAM_HI  = 32'h0000_9FFF,
  parameter logic [31:0] FCFG_LO  = 32'h0000_0A80,
  parameter logic [31:0] FCFG_HI  = 32'h0000_0ADF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] rd_code_addr,
  input  logic [WORD_W-1:0] rd_mem_data,
  input  logic              zone_locked,
  input  logic              pw_hit,
  output logic [WORD_W-1:0] rd_data_out,
  output logic              rd_viol
);

  logic code_sec, data_sec, blocked;

  always_comb begin
    code_sec = in_win(32'(rd_code_addr), FLASH_LO, FLASH_HI) ||
               in_win(32'(rd_code_addr), SRAM_LO, SRAM_HI);
    data_sec = in_win(32'(rd_addr), FLASH_LO, FLASH_HI) ||
               in_win(32'(rd_addr), SRAM_LO, SRAM_HI) ||
               in_win(32'(rd_addr), FCFG_LO, FCFG_HI);
    blocked  = rd_req && zone_locked && data_sec && !code_sec;
    rd_data_out = blocked ? '0 : rd_mem_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_viol <= 1'b0;
    else        rd_viol <= blocked && !pw_hit;
  end

  // R12: an open zone never masks data.
  a_r12_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !zone_locked) |-> (rd_data_out == rd_mem_data));

  // R8: a violation follows a read made while locked.
  a_r8_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_viol |-> $past(rd_req && zone_locked));

  // R11: password reads never raise a violation.
  a_r11_pw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && pw_hit) |=> !rd_viol);

endmodule

// File: rtl/seczone_ctrl.sv
`timescale 1ns/1ps
module seczone_ctrl #(
  parameter int          ADDR_W    = 22,
  parameter int          WORD_W    = 16,
  parameter int          KEY_WORDS = 8,
  parameter logic [31:0] PW_BASE   = 32'h003F_7FF8,
  parameter logic [31:0] FLASH_LO  = 32'h003E_8000,
  parameter logic [31:0] FLASH_HI  = 32'h003F_7FFF,
  parameter logic [31:0] SRAM_LO   = 32'h0000_8000,
  parameter logic [31:0] SRAM_HI   = 32'h0000_9FFF,
  parameter logic [31:0] FCFG_LO   = 32'h0000_0A80,
  parameter logic [31:0] FCFG_HI   = 32'h0000_0ADF,
  localparam int IDX_W = $clog2(KEY_WORDS),
  localparam int KEY_W = KEY_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr_en,
  input  logic [IDX_W-1:0]  key_wr_idx,
  input  logic [WORD_W-1:0] key_wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] rd_code_addr,
  input  logic [WORD_W-1:0] rd_mem_data,
  output logic [WORD_W-1:0] rd_data_out,
  output logic              zone_locked,
  output logic              dbg_locked,
  output logic              rd_viol
);

  logic [KEY_W-1:0] key_flat;
  logic [KEY_W-1:0] pw_flat;
  logic             pass_done;
  logic             pw_hit;

  sz_key_bank #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS)) u_keys (
    .clk(clk), .rst_n(rst_n), .wr_en(key_wr_en), .wr_idx(key_wr_idx),
    .wr_data(key_wr_data), .key_flat(key_flat));

  sz_pw_tracker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS),
                  .PW_BASE(PW_BASE)) u_track (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr_en), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_mem_data(rd_mem_data), .pw_hit(pw_hit),
    .pass_done(pass_done), .pw_flat(pw_flat));

  sz_lock_eval #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS)) u_eval (
    .key_flat(key_flat), .pw_flat(pw_flat), .pass_done(pass_done),
    .zone_locked(zone_locked), .dbg_locked(dbg_locked));

  sz_access_filter #(.ADDR_W(ADDR_W), .WORD_W(WORD_W),
                     .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI),
                     .SRAM_LO(SRAM_LO), .SRAM_HI(SRAM_HI),
                     .FCFG_LO(FCFG_LO), .FCFG_HI(FCFG_HI)) u_filt (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_code_addr(rd_code_addr), .rd_mem_data(rd_mem_data),
    .zone_locked(zone_locked), .pw_hit(pw_hit),
    .rd_data_out(rd_data_out), .rd_viol(rd_viol));

  // R2: no lock is released before the dummy-read pass completes.
  a_r2_zone_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !zone_locked |-> pass_done);
  a_r2_dbg_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_locked |-> pass_done);

  // R3: an open zone implies debug is free as well.
  a_r3_open_frees_dbg: assert property (@(posedge clk) disable iff (!rst_n)
    !zone_locked |-> !dbg_locked);

endmodule

// File: tb/seczone_ctrl_tb_top.sv
`timescale 1ns/1ps
module seczone_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_wr_en = 1'b0;
  logic [2:0]  key_wr_idx = '0;
  logic [15:0] key_wr_data = '0;
  logic        rd_req = 1'b0;
  logic [21:0] rd_addr = '0;
  logic [21:0] rd_code_addr = '0;
  logic [15:0] rd_mem_data = '0;
  logic [15:0] rd_data_out;
  logic        zone_locked, dbg_locked, rd_viol;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] pwm [8];

  localparam logic [21:0] NS_CODE = 22'h000400;
  localparam logic [21:0] SC_CODE = 22'h3E8100;
  localparam logic [21:0] PW_AT   = 22'h3F7FF8;

  always #5 clk = ~clk;

  seczone_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .key_wr_en(key_wr_en), .key_wr_idx(key_wr_idx),
    .key_wr_data(key_wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_code_addr(rd_code_addr), .rd_mem_data(rd_mem_data),
    .rd_data_out(rd_data_out), .zone_locked(zone_locked),
    .dbg_locked(dbg_locked), .rd_viol(rd_viol));

  typedef struct packed {
    logic [21:0] code;
    logic [21:0] addr;
    logic [15:0] mem;
    logic [15:0] exp;
    logic        viol;
    logic [7:0]  req;
  } vec_t;

  // Locked-zone classification vectors.
  localparam vec_t VECS [11] = '{
    '{22'h000400, 22'h3F0000, 16'hBEEF, 16'h0000, 1'b1, 8'd8 },  // R8 flash
    '{22'h000400, 22'h008020, 16'h1234, 16'h0000, 1'b1, 8'd8 },  // R8 sram
    '{22'h3E8100, 22'h3F0000, 16'hBEEF, 16'hBEEF, 1'b0, 8'd9 },  // R9
    '{22'h008010, 22'h3E9000, 16'h5A5A, 16'h5A5A, 1'b0, 8'd9 },  // R9
    '{22'h000400, 22'h007100, 16'h00C3, 16'h00C3, 1'b0, 8'd10},  // R10 periph
    '{22'h000400, 22'h000A80, 16'h7777, 16'h0000, 1'b1, 8'd10},  // R10 fcfg
    '{22'h3E8100, 22'h000ADF, 16'h8888, 16'h8888, 1'b0, 8'd10},  // R10 fcfg
    '{22'h000400, 22'h000600, 16'h4321, 16'h4321, 1'b0, 8'd10},  // R10 ram
    '{22'h000400, 22'h3E7FFF, 16'h1111, 16'h1111, 1'b0, 8'd10},  // R10 edge
    '{22'h000400, 22'h00A000, 16'h2222, 16'h2222, 1'b0, 8'd10},  // R10 edge
    '{22'h000400, 22'h3F7FFA, 16'h9999, 16'h0000, 1'b0, 8'd11}   // R11
  };

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [21:0] code, input logic [21:0] addr,
                         input logic [15:0] data, input logic [15:0] exp_d,
                         input logic exp_v, input string req);
    @(negedge clk);
    rd_req = 1'b1; rd_code_addr = code; rd_addr = addr; rd_mem_data = data;
    #1 chk({req, " data"}, 32'(rd_data_out), 32'(exp_d));
    @(negedge clk);
    rd_req = 1'b0;
    chk({req, " viol"}, 32'(rd_viol), 32'(exp_v));
  endtask

  task automatic key_wr(input int idx, input logic [15:0] val);
    @(negedge clk);
    key_wr_en = 1'b1; key_wr_idx = 3'(idx); key_wr_data = val;
    @(negedge clk);
    key_wr_en = 1'b0;
  endtask

  task automatic pw_read(input int k, input string req);
    do_read(NS_CODE, PW_AT + 22'(k), pwm[k], 16'h0000, 1'b0, req);
  endtask

  task automatic locks(input logic z, input logic d, input string req);
    chk({req, " zone_locked"}, 32'(zone_locked), 32'(z));
    chk({req, " dbg_locked"}, 32'(dbg_locked), 32'(d));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    pwm = '{16'h1A2B, 16'h3C4D, 16'h5E6F, 16'h7081,
            16'h92A3, 16'hB4C5, 16'hD6E7, 16'hF809};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    locks(1'b1, 1'b1, "R1 reset");
    chk("R1 reset viol", 32'(rd_viol), 32'd0);

    for (int i = 0; i < 11; i++)
      do_read(VECS[i].code, VECS[i].addr, VECS[i].mem, VECS[i].exp,
              VECS[i].viol, $sformatf("R%0d vec%0d", VECS[i].req, i));

    // R4: lower-half key only.
    for (int i = 0; i < 8; i++) key_wr(i, (i < 4) ? pwm[i] : 16'h0000);
    for (int i = 0; i < 7; i++) pw_read(i, "R11 pass");
    locks(1'b1, 1'b1, "R2 seven words");
    pw_read(0, "R11 pass");
    locks(1'b1, 1'b1, "R2 repeat word");
    pw_read(7, "R11 pass");
    locks(1'b1, 1'b0, "R4 half match");
    do_read(NS_CODE, 22'h3F0000, 16'hBEEF, 16'h0000, 1'b1, "R4 still blocked");

    // R3 full match, pass in reverse order.
    key_wr(4, pwm[4]);
    locks(1'b1, 1'b1, "R7 key write");
    for (int i = 5; i < 8; i++) key_wr(i, pwm[i]);
    for (int i = 7; i >= 0; i--) pw_read(i, "R11 pass");
    locks(1'b0, 1'b0, "R3 full match");
    do_read(NS_CODE, 22'h3F0000, 16'hBEEF, 16'hBEEF, 1'b0, "R12 flash");
    do_read(NS_CODE, 22'h000A90, 16'h6161, 16'h6161, 1'b0, "R12 fcfg");
    do_read(NS_CODE, PW_AT + 22'd3, pwm[3], pwm[3], 1'b0, "R12 pw");

    // R7: same key value rewritten still relocks.
    key_wr(0, pwm[0]);
    locks(1'b1, 1'b1, "R7 same value");
    for (int i = 0; i < 8; i++) pw_read(i, "R11 pass");
    locks(1'b0, 1'b0, "R3 after repass");

    // R5: blank lower password half.
    for (int i = 0; i < 4; i++) pwm[i] = 16'hFFFF;
    key_wr(0, 16'h0000);
    for (int i = 0; i < 8; i++) pw_read(i, "R11 pass");
    locks(1'b1, 1'b0, "R5 blank low half");

    // R6: fully blank password.
    for (int i = 4; i < 8; i++) pwm[i] = 16'hFFFF;
    key_wr(1, 16'h0000);
    for (int i = 0; i < 8; i++) pw_read(i, "R11 pass");
    locks(1'b0, 1'b0, "R6 blank password");

    // R1: reset from the open state.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    locks(1'b1, 1'b1, "R1 re-reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule